// File: doc/BRIEF.md
# Per-Destination EOI Pending Tracker

This block follows the acknowledgements still owed for one edge-triggered interrupt pin that may be sent to as many as `NUM_DEST` destination processors. When the pin is delivered, the block records which destinations took the interrupt in a bitmap, and loads a pending count from the delivery result. Each end-of-interrupt (EOI) from a destination whose bitmap bit is set retires one owed acknowledgement. While any acknowledgement is owed, a new assertion of the pin is flagged as coalesced, and the interrupt controller drops it instead of delivering it.

The bitmap and the count come from separate inputs, so they can disagree. If an EOI or a resync would drive the count below zero, the tracker rebuilds itself from the live per-destination pending flags and the routing match mask. A resync request changes the bitmap only for the matching destinations whose live flag differs from the tracker's bit. Destination matching and the delivery itself are done outside this block.

Top module: `eoi_pend_tracker`

## Requirements
- R1: `coalesced_o` is high exactly when the registered pending count is nonzero.
- R2: A delivery with a pending count of zero loads the bitmap with `deliver_mask_i`. It loads the count with `deliver_cnt_i` (two's complement), clamped to the range 0 to `NUM_DEST`, so a negative value loads 0.
- R3: A delivery that arrives while the pending count, after any same-cycle EOI and resync, is nonzero is rejected. Bitmap and count stay unchanged, and `deliver_err_o` is high for the following cycle.
- R4: An EOI whose destination index (`eoi_dest_i`, bit position in the bitmap) has its bit set, while the count is nonzero, clears that bit and decrements the count by one.
- R5: An EOI whose destination bit is clear leaves the bitmap and the count unchanged.
- R6: An EOI whose destination bit is set while the count is zero triggers a rebuild. The bitmap becomes `live_pend_i & match_i`, the count becomes the number of ones in it, and `rebuild_o` is high for the following cycle.
- R7: A resync sets or clears each bitmap bit whose destination is in `match_i` so that it equals `live_pend_i`. The count moves up by one for each bit set and down by one for each bit cleared. Bits outside `match_i` keep their value.
- R8: A resync whose net change would take the count below zero performs the rebuild of R6 instead, and raises `rebuild_o`.
- R9: Within one cycle the EOI is applied first, then the resync, then the delivery. Each step sees the result of the step before it.
- R10: Reset clears the bitmap, the count, `deliver_err_o` and `rebuild_o`.
- R11: All results are registered. They appear after the single rising clock edge that samples the inputs, and none before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deliver_i | input | 1 | Pin was delivered this cycle |
| deliver_mask_i | input | NUM_DEST | Destinations that accepted the delivery |
| deliver_cnt_i | input | CNT_W+1 | Signed delivery result count |
| eoi_i | input | 1 | EOI pulse |
| eoi_dest_i | input | IDX_W | Index of the acknowledging destination |
| resync_i | input | 1 | Resync request |
| live_pend_i | input | NUM_DEST | Live per-destination pending flags |
| match_i | input | NUM_DEST | Destinations the pin is routed to |
| coalesced_o | output | 1 | A new assertion would be coalesced |
| pend_cnt_o | output | CNT_W | Pending acknowledgement count |
| pend_map_o | output | NUM_DEST | Destinations still owing an EOI |
| deliver_err_o | output | 1 | Previous cycle's delivery was rejected |
| rebuild_o | output | 1 | Previous cycle rebuilt from live flags |

## Verification
Every result of this block, including the coalesced flag, the count, the bitmap and the two event flags, is due one rising edge after the cycle whose inputs cause it. The bench drives each stimulus on a falling edge and reads the outputs on the next falling edge, after exactly one rising edge has passed. For one delivery it also reads the outputs just before that edge, to show that nothing leaks through early. The cases where several inputs arrive in the same cycle depend only on the EOI, then resync, then delivery order. The bench computes their expected values by applying that order by hand.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

  localparam int MAX_DEST = 32;

  // number of ones in a destination vector (zero-extended to MAX_DEST)
  function automatic int unsigned pop_cnt(input logic [MAX_DEST-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < MAX_DEST; i++) n += int'(v[i]);
    return n;
  endfunction

  // limit a signed delivery result to the range 0..hi
  function automatic int clamp_cnt(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  // count after adding nset bits and removing nclr bits (may go negative)
  function automatic int net_cnt(input int cur, input int unsigned nset,
                                 input int unsigned nclr);
    return cur + int'(nset) - int'(nclr);
  endfunction

endpackage

// File: rtl/eoi_ack_stage.sv
module eoi_ack_stage #(
  parameter int NUM_DEST = 16,
  parameter int CNT_W    = 5,
  parameter int IDX_W    = 4
) (
  input  logic                eoi_i,
  input  logic [IDX_W-1:0]    dest_i,
  input  logic [NUM_DEST-1:0] map_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [NUM_DEST-1:0] rb_map_i,
  input  logic [CNT_W-1:0]    rb_cnt_i,
  output logic [NUM_DEST-1:0] map_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                underflow_o
);
  logic hit;

  always_comb begin
    hit         = eoi_i && map_i[dest_i];
    map_o       = map_i;
    cnt_o       = cnt_i;
    underflow_o = 1'b0;
    if (hit) begin
      if (cnt_i == '0) begin
        underflow_o = 1'b1;
        map_o       = rb_map_i;
        cnt_o       = rb_cnt_i;
      end else begin
        map_o[dest_i] = 1'b0;
        cnt_o         = cnt_i - CNT_W'(1);
      end
    end
  end

  // R5: an EOI on a clear bit passes state through
  always_comb
    if (eoi_i && !map_i[dest_i])
      p_eoi_miss_r5: assert (map_o == map_i && cnt_o == cnt_i);

endmodule

// File: rtl/resync_stage.sv
module resync_stage
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int CNT_W    = 5
) (
  input  logic                resync_i,
  input  logic [NUM_DEST-1:0] live_i,
  input  logic [NUM_DEST-1:0] match_i,
  input  logic [NUM_DEST-1:0] map_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [NUM_DEST-1:0] rb_map_i,
  input  logic [CNT_W-1:0]    rb_cnt_i,
  output logic [NUM_DEST-1:0] map_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                fallback_o
);
  logic [NUM_DEST-1:0] to_set, to_clr;
  int                  next_cnt;

  always_comb begin
    to_set     = live_i & match_i & ~map_i;
    to_clr     = map_i & match_i & ~live_i;
    next_cnt   = net_cnt(int'(cnt_i), pop_cnt(MAX_DEST'(to_set)),
                         pop_cnt(MAX_DEST'(to_clr)));
    map_o      = map_i;
    cnt_o      = cnt_i;
    fallback_o = 1'b0;
    if (resync_i) begin
      if (next_cnt < 0) begin
        fallback_o = 1'b1;
        map_o      = rb_map_i;
        cnt_o      = rb_cnt_i;
      end else begin
        map_o = (map_i | to_set) & ~to_clr;
        cnt_o = CNT_W'(next_cnt);
      end
    end
  end

  // R7: destinations outside the match mask keep their bit
  always_comb
    if (resync_i && !fallback_o)
      p_unmatched_kept_r7: assert (((map_o ^ map_i) & ~match_i) == '0);

endmodule

// File: rtl/deliver_stage.sv
module deliver_stage
  import eoi_trk_pkg::*;
#(
  parameter int NUM_DEST = 16,
  parameter int CNT_W    = 5
) (
  input  logic                deliver_i,
  input  logic [NUM_DEST-1:0] mask_i,
  input  logic signed [CNT_W:0] dcnt_i,
  input  logic [NUM_DEST-1:0] map_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [NUM_DEST-1:0] map_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                reject_o
);
  always_comb begin
    map_o    = map_i;
    cnt_o    = cnt_i;
    reject_o = 1'b0;
    if (deliver_i) begin
      if (cnt_i != '0) begin
        reject_o = 1'b1;
      end else begin
        map_o = mask_i;
        cnt_o = CNT_W'(clamp_cnt(int'(dcnt_i), NUM_DEST));
      end
    end
  end

  // R3: a rejected delivery leaves state untouched
  always_comb
    if (deliver_i && cnt_i != '0)
      p_reject_hold_r3: assert (map_o == map_i && cnt_o == cnt_i);

endmodule

// File: rtl/eoi_pend_tracker.sv
module eoi_pend_tracker
  import eoi_trk_pkg::*;
#(
  parameter  int NUM_DEST = 16,
  localparam int CNT_W    = $clog2(NUM_DEST + 1),
  localparam int IDX_W    = $clog2(NUM_DEST)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  deliver_i,
  input  logic [NUM_DEST-1:0]   deliver_mask_i,
  input  logic signed [CNT_W:0] deliver_cnt_i,
  input  logic                  eoi_i,
  input  logic [IDX_W-1:0]      eoi_dest_i,
  input  logic                  resync_i,
  input  logic [NUM_DEST-1:0]   live_pend_i,
  input  logic [NUM_DEST-1:0]   match_i,
  output logic                  coalesced_o,
  output logic [CNT_W-1:0]      pend_cnt_o,
  output logic [NUM_DEST-1:0]   pend_map_o,
  output logic                  deliver_err_o,
  output logic                  rebuild_o
);
  logic [NUM_DEST-1:0] map_q, rb_map, map_a, map_b, map_c;
  logic [CNT_W-1:0]    cnt_q, rb_cnt, cnt_a, cnt_b, cnt_c;
  logic                err_q, rb_q;
  // named internal events
  logic                ev_underflow, ev_fallback, ev_reject;

  assign rb_map = live_pend_i & match_i;
  assign rb_cnt = CNT_W'(pop_cnt(MAX_DEST'(rb_map)));

  eoi_ack_stage #(.NUM_DEST(NUM_DEST), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ack (
    .eoi_i(eoi_i), .dest_i(eoi_dest_i), .map_i(map_q), .cnt_i(cnt_q),
    .rb_map_i(rb_map), .rb_cnt_i(rb_cnt),
    .map_o(map_a), .cnt_o(cnt_a), .underflow_o(ev_underflow));

  resync_stage #(.NUM_DEST(NUM_DEST), .CNT_W(CNT_W)) u_rsy (
    .resync_i(resync_i), .live_i(live_pend_i), .match_i(match_i),
    .map_i(map_a), .cnt_i(cnt_a), .rb_map_i(rb_map), .rb_cnt_i(rb_cnt),
    .map_o(map_b), .cnt_o(cnt_b), .fallback_o(ev_fallback));

  deliver_stage #(.NUM_DEST(NUM_DEST), .CNT_W(CNT_W)) u_dlv (
    .deliver_i(deliver_i), .mask_i(deliver_mask_i), .dcnt_i(deliver_cnt_i),
    .map_i(map_b), .cnt_i(cnt_b),
    .map_o(map_c), .cnt_o(cnt_c), .reject_o(ev_reject));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      rb_q  <= 1'b0;
    end else begin
      map_q <= map_c;
      cnt_q <= cnt_c;
      err_q <= ev_reject;
      rb_q  <= ev_underflow | ev_fallback;
    end
  end

  assign coalesced_o   = (cnt_q != '0);
  assign pend_cnt_o    = cnt_q;
  assign pend_map_o    = map_q;
  assign deliver_err_o = err_q;
  assign rebuild_o     = rb_q;

  // R2: count never exceeds the number of destinations
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= NUM_DEST);

  // R4: a lone EOI on a set bit with count nonzero retires exactly one
  p_eoi_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !resync_i && !deliver_i && map_q[eoi_dest_i] && cnt_q != '0)
    |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && !pend_map_o[$past(eoi_dest_i)]);

  // R6: after a rebuild the count equals the bitmap population
  p_rebuild_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rebuild_o |-> int'(cnt_q) == int'(pop_cnt(MAX_DEST'(map_q))));

  // R3: a rejection flag only follows a delivery request
  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    deliver_err_o |-> $past(deliver_i));

  // R11: with no request, state holds across the edge
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_i && !resync_i && !deliver_i) |=> $stable(map_q) && $stable(cnt_q));

endmodule

// File: tb/sim_eoi_pend_tracker.sv
module sim_eoi_pend_tracker;
  localparam int ND = 16;
  localparam int CW = 5;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          deliver = 1'b0;
  logic [ND-1:0] dmask = '0;
  logic signed [CW:0] dcnt = '0;
  logic          eoi = 1'b0;
  logic [IW-1:0] edest = '0;
  logic          resync = 1'b0;
  logic [ND-1:0] live = '0;
  logic [ND-1:0] match = '0;
  logic          coal, derr, rbld;
  logic [CW-1:0] pcnt;
  logic [ND-1:0] pmap;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eoi_pend_tracker #(.NUM_DEST(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .deliver_i(deliver), .deliver_mask_i(dmask),
    .deliver_cnt_i(dcnt), .eoi_i(eoi), .eoi_dest_i(edest), .resync_i(resync),
    .live_pend_i(live), .match_i(match), .coalesced_o(coal),
    .pend_cnt_o(pcnt), .pend_map_o(pmap), .deliver_err_o(derr),
    .rebuild_o(rbld));

  typedef struct packed {
    logic        dl;  logic [15:0] dm; logic [31:0] dc;
    logic        eo;  logic [3:0]  ed;
    logic        rs;  logic [15:0] lv; logic [15:0] mt;
    logic [7:0]  xc;  logic [15:0] xm; logic xe; logic xr;
    logic [7:0]  rq;
  } vec_t;

  // dl dm dc | eo ed | rs lv mt | exp cnt map err rb | req
  localparam vec_t VECS [23] = '{
    '{1,16'h0005,32'd2,   0,0,  0,16'h0,16'h0,     8'd2, 16'h0005,0,0, 8'd2}, // R2
    '{0,16'h0,32'd0,      1,0,  0,16'h0,16'h0,     8'd1, 16'h0004,0,0, 8'd4}, // R4
    '{0,16'h0,32'd0,      1,1,  0,16'h0,16'h0,     8'd1, 16'h0004,0,0, 8'd5}, // R5
    '{1,16'h00F0,32'd4,   0,0,  0,16'h0,16'h0,     8'd1, 16'h0004,1,0, 8'd3}, // R3
    '{1,16'h0300,32'd2,   1,2,  0,16'h0,16'h0,     8'd2, 16'h0300,0,0, 8'd9}, // R9
    '{0,16'h0,32'd0,      1,8,  0,16'h0,16'h0,     8'd1, 16'h0200,0,0, 8'd4}, // R4
    '{0,16'h0,32'd0,      1,9,  0,16'h0,16'h0,     8'd0, 16'h0000,0,0, 8'd1}, // R1
    '{1,16'h8001,-32'sd3, 0,0,  0,16'h0,16'h0,     8'd0, 16'h8001,0,0, 8'd2}, // R2
    '{0,16'h0,32'd0,      1,15, 0,16'h0010,16'h00FF,8'd1,16'h0010,0,1, 8'd6}, // R6
    '{0,16'h0,32'd0,      0,0,  1,16'h0003,16'h000F,8'd3,16'h0013,0,0, 8'd7}, // R7
    '{0,16'h0,32'd0,      0,0,  1,16'h0000,16'h0010,8'd2,16'h0003,0,0, 8'd7}, // R7
    '{0,16'h0,32'd0,      1,0,  0,16'h0,16'h0,     8'd1, 16'h0002,0,0, 8'd4}, // R4
    '{0,16'h0,32'd0,      1,1,  0,16'h0,16'h0,     8'd0, 16'h0000,0,0, 8'd4}, // R4
    '{1,16'hFFFF,32'd31,  0,0,  0,16'h0,16'h0,     8'd16,16'hFFFF,0,0, 8'd2}, // R2
    '{0,16'h0,32'd0,      0,0,  1,16'h0000,16'hFFFF,8'd0,16'h0000,0,0, 8'd7}, // R7
    '{1,16'h0007,32'd1,   0,0,  0,16'h0,16'h0,     8'd1, 16'h0007,0,0, 8'd2}, // R2
    '{0,16'h0,32'd0,      0,0,  1,16'h0100,16'h0107,8'd1,16'h0100,0,1, 8'd8}, // R8
    '{0,16'h0,32'd0,      1,8,  0,16'h0,16'h0,     8'd0, 16'h0000,0,0, 8'd4}, // R4
    '{1,16'h0000,32'd0,   0,0,  0,16'h0,16'h0,     8'd0, 16'h0000,0,0, 8'd1}, // R1
    '{1,16'h0030,32'd2,   0,0,  0,16'h0,16'h0,     8'd2, 16'h0030,0,0, 8'd2}, // R2
    '{1,16'h0C00,32'd2,   1,4,  1,16'h0000,16'h0020,8'd2,16'h0C00,0,0, 8'd9}, // R9
    '{0,16'h0,32'd0,      1,10, 0,16'h0,16'h0,     8'd1, 16'h0800,0,0, 8'd4}, // R4
    '{0,16'h0,32'd0,      1,11, 0,16'h0,16'h0,     8'd0, 16'h0000,0,0, 8'd1}  // R1
  };

  task automatic chk(input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    deliver = 1'b0; dmask = '0; dcnt = '0; eoi = 1'b0; edest = '0;
    resync = 1'b0; live = '0; match = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10: reset state
    chk(10, "reset cnt", 32'(pcnt), 0);
    chk(10, "reset map", 32'(pmap), 0);
    chk(10, "reset coal", 32'(coal), 0);
    chk(10, "reset err/rb", 32'({derr, rbld}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      deliver = VECS[i].dl; dmask = VECS[i].dm; dcnt = (CW+1)'(VECS[i].dc);
      eoi = VECS[i].eo; edest = VECS[i].ed;
      resync = VECS[i].rs; live = VECS[i].lv; match = VECS[i].mt;
      @(negedge clk);
      chk(int'(VECS[i].rq), $sformatf("vec%0d cnt", i), 32'(pcnt), 32'(VECS[i].xc));
      chk(int'(VECS[i].rq), $sformatf("vec%0d map", i), 32'(pmap), 32'(VECS[i].xm));
      chk(1, $sformatf("vec%0d coal", i), 32'(coal), 32'(VECS[i].xc != 0));
      chk(3, $sformatf("vec%0d err", i), 32'(derr), 32'(VECS[i].xe));
      chk(6, $sformatf("vec%0d rebuild", i), 32'(rbld), 32'(VECS[i].xr));
    end
    idle_inputs();
    @(negedge clk);

    // R11: delivery result not visible before the sampling edge
    deliver = 1'b1; dmask = 16'h0040; dcnt = 6'sd1;
    #2;
    chk(11, "coal before edge", 32'(coal), 0);
    @(negedge clk);
    idle_inputs();
    chk(11, "coal after edge", 32'(coal), 1);
    chk(11, "map after edge", 32'(pmap), 32'h0040);

    // R5: EOI on a clear bit with count nonzero changes nothing
    eoi = 1'b1; edest = 4'd3;
    @(negedge clk);
    idle_inputs();
    chk(5, "miss eoi cnt", 32'(pcnt), 1);
    chk(5, "miss eoi map", 32'(pmap), 32'h0040);

    // R10: reset in mid-run clears owed state
    rst_n = 1'b0;
    @(negedge clk);
    chk(10, "midrun reset cnt", 32'(pcnt), 0);
    chk(10, "midrun reset map", 32'(pmap), 0);
    chk(10, "midrun reset coal", 32'(coal), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule